// File: doc/BRIEF.md
# SPI Command Response Checker

This host-side block runs right after a command has been shifted out to a SPI-attached device, and it decides whether the device's reply is acceptable. The block pulls one dummy byte at a time from a byte-wide SPI shifter. In command-response mode it first waits for the device to echo the opcode. It then waits for a zero status byte. Each of these two stages has a bounded number of attempts. In data-header mode it waits instead for a byte whose upper nibble is all ones. That byte marks the start of a read payload, and the payload itself is handled elsewhere.

When a check runs out of attempts, the block does not report at once. It first clocks out a run of all-ones bytes so that the device's SPI front end is flushed. Only then does it report the failure. The sequencer can also call this all-ones run directly as a fallback reset. In that case the result depends on the last byte received. Every operation ends with a one-cycle `done` pulse, and `ok` carries the verdict in the same cycle.

Top module: `spi_rsp_checker`

## Requirements
- R1: In command-response mode (mode 2'b00), received bytes are compared with the opcode captured at start. The echo stage accepts a match on any of the first RETRIES+1 bytes (11 by default) and then moves on to the status stage.
- R2: The status stage reloads its attempt budget when it is entered. It accepts a byte equal to 8'h00 on any of the first RETRIES+1 bytes it receives, and acceptance ends the operation with `ok`=1.
- R3: In data-header mode (mode 2'b01), a byte whose bits [7:4] equal 4'hF is accepted on any of the first HDR_TRIES bytes (10 by default), and acceptance ends the operation with `ok`=1.
- R4: In fallback-reset mode (mode 2'b10), the block requests exactly FLUSH_BYTES bytes (8 by default) with `tx_byte`=8'hFF. It then reports `ok`=1 only if the last received byte is 8'hFF.
- R5: When the echo, status or header stage runs out of attempts, the block first requests FLUSH_BYTES bytes with `tx_byte`=8'hFF. It then ends with `ok`=0, whatever the flushed bytes were.
- R6: `done` is a one-cycle pulse that appears on the cycle after the final byte is taken. `ok` is never high without `done`.
- R7: `byte_req` is high exactly while an operation is in progress. During the check stages `tx_byte` is 8'h00, and during a flush it is 8'hFF.
- R8: A `start` that arrives while an operation is in progress is ignored. A byte received while the block is idle is ignored. Once a stage has accepted its byte, that byte is not counted by the next stage.
- R9: Mode 2'b11 is reserved. Starting it requests no byte and gives `done`=1 with `ok`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| mode | input | 2 | 00 command response, 01 data header, 10 fallback reset, 11 reserved |
| opcode | input | 8 | Expected echo, captured at start |
| byte_req | output | 1 | Asks the shifter for another byte |
| tx_byte | output | 8 | Byte the shifter sends while it receives |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Verdict, valid with done |

## Verification
The bench builds the block with the default bounds: RETRIES=10, HDR_TRIES=10 and FLUSH_BYTES=8. These values place the last accepted attempt and the first exhausted attempt of every stage within a few dozen bytes. The bench therefore drives each stage to both sides of its limit: a match on the final allowed byte, and one more miss that forces the flush. The eight-byte flush is short enough to run both as a recovery path and as a standalone reset, with good and bad final bytes.

// File: rtl/spi_rsp_checker.sv
module spi_rsp_checker #(
  parameter int RETRIES     = 10,
  parameter int HDR_TRIES   = 10,
  parameter int FLUSH_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic [7:0] opcode,
  output logic       byte_req,
  output logic [7:0] tx_byte,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       done,
  output logic       ok
);
  localparam int CW = $clog2(RETRIES + HDR_TRIES + FLUSH_BYTES + 1);
  localparam logic [CW-1:0] RET_LD = CW'(RETRIES);
  localparam logic [CW-1:0] HDR_LD = CW'(HDR_TRIES - 1);
  localparam logic [CW-1:0] FL_LD  = CW'(FLUSH_BYTES - 1);

  typedef enum logic [2:0] {IDLE, ECHO, STAT, HDR, FLUSH} st_t;

  st_t           st;
  logic [7:0]    op_q;
  logic [CW-1:0] cnt;
  logic          standalone;
  logic          done_q, ok_q;

  assign byte_req = (st != IDLE);
  assign tx_byte  = (st == FLUSH) ? 8'hFF : 8'h00;
  assign done     = done_q;
  assign ok       = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      op_q       <= 8'h00;
      cnt        <= '0;
      standalone <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      case (st)
        IDLE:
          if (start) begin
            op_q <= opcode;
            case (mode)
              2'b00: begin st <= ECHO; cnt <= RET_LD; end
              2'b01: begin st <= HDR;  cnt <= HDR_LD; end
              2'b10: begin st <= FLUSH; cnt <= FL_LD; standalone <= 1'b1; end
              default: done_q <= 1'b1;
            endcase
          end
        ECHO, STAT, HDR:
          if (rx_valid) begin
            if ((st == ECHO && rx_byte == op_q) ||
                (st == STAT && rx_byte == 8'h00) ||
                (st == HDR  && rx_byte[7:4] == 4'hF)) begin
              if (st == ECHO) begin
                st  <= STAT;
                cnt <= RET_LD;
              end else begin
                st     <= IDLE;
                done_q <= 1'b1;
                ok_q   <= 1'b1;
              end
            end else if (cnt == '0) begin
              st         <= FLUSH;
              cnt        <= FL_LD;
              standalone <= 1'b0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        FLUSH:
          if (rx_valid) begin
            if (cnt == '0) begin
              st     <= IDLE;
              done_q <= 1'b1;
              ok_q   <= standalone && (rx_byte == 8'hFF);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module spi_rsp_checker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic       byte_req,
  input logic [7:0] tx_byte,
  input logic       rx_valid,
  input logic       done,
  input logic       ok
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !ok);
  // R7
  flush_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (tx_byte == 8'hFF) |-> byte_req);
  // R7
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !byte_req);
  // R8
  idle_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_req && rx_valid && !start) |=> (!done && !byte_req));
  // R9
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_req && start && mode == 2'b11) |=> (done && !ok && !byte_req));
endmodule

bind spi_rsp_checker spi_rsp_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .byte_req(byte_req),
  .tx_byte(tx_byte), .rx_valid(rx_valid), .done(done), .ok(ok)
);

// File: tb/tb_spi_rsp_checker.sv
module tb_spi_rsp_checker;
  logic clk = 0, rst_n = 0, start = 0, rx_valid = 0;
  logic [1:0] mode = 0;
  logic [7:0] opcode = 0, rx_byte = 0;
  logic byte_req, done, ok;
  logic [7:0] tx_byte;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_rsp_checker dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opcode(opcode), .byte_req(byte_req), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .done(done), .ok(ok));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] m, input logic [7:0] op);
    @(negedge clk); start = 1; mode = m; opcode = op;
    @(negedge clk); start = 0;
  endtask

  task automatic give(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic flush_and_expect(input string tag, input logic last, input logic exp_ok);
    check({tag, " flush tx"}, tx_byte, 8'hFF);
    for (int i = 0; i < 7; i++) give(8'hFF);
    check({tag, " not done before last"}, done, 0);
    give(last ? 8'hFF : 8'h7E);
    check({tag, " done"}, done, 1);
    check({tag, " ok"}, ok, exp_ok);
    @(negedge clk);
    check({tag, " done pulse"}, done, 0);
  endtask

  task automatic t_reset;
    check("reset done", done, 0);
    check("reset ok", ok, 0);
    check("R7 reset byte_req", byte_req, 0);
  endtask

  task automatic t_echo_fast;
    go(2'b00, 8'hC9);
    check("R7 req while busy", byte_req, 1);
    check("R7 tx dummy", tx_byte, 8'h00);
    give(8'hC9);
    check("R1 echo accepted, not done", done, 0);
    give(8'h00);
    check("R2 status done", done, 1);
    check("R2 status ok", ok, 1);
    check("R7 req drops", byte_req, 0);
    @(negedge clk);
    check("R6 done one cycle", done, 0);
  endtask

  task automatic t_echo_late;
    go(2'b00, 8'hCA);
    for (int i = 0; i < 10; i++) give(8'h55);
    check("R1 still hunting", done, 0);
    check("R1 still checking tx", tx_byte, 8'h00);
    give(8'hCA);
    for (int i = 0; i < 10; i++) give(8'h33);
    check("R2 reloaded budget", done, 0);
    give(8'h00);
    check("R2 last attempt ok", ok, 1);
    check("R6 done with ok", done, 1);
  endtask

  task automatic t_echo_fail;
    go(2'b00, 8'hC4);
    for (int i = 0; i < 11; i++) give(8'h55);
    check("R5 no early failure", done, 0);
    flush_and_expect("R5 echo exhausted", 1'b1, 1'b0);
  endtask

  task automatic t_stat_fail;
    go(2'b00, 8'hC3);
    give(8'hC3);
    give(8'hC3);
    for (int i = 0; i < 10; i++) give(8'h01);
    check("R8 echo not reused by status", tx_byte, 8'hFF);
    flush_and_expect("R5 status exhausted", 1'b1, 1'b0);
  endtask

  task automatic t_hdr;
    go(2'b01, 8'h00);
    for (int i = 0; i < 9; i++) give(8'h3F);
    check("R3 hunting", done, 0);
    give(8'hF3);
    check("R3 tenth attempt done", done, 1);
    check("R3 tenth attempt ok", ok, 1);
    go(2'b01, 8'h00);
    for (int i = 0; i < 10; i++) give(8'hEF);
    flush_and_expect("R3 R5 header exhausted", 1'b1, 1'b0);
  endtask

  task automatic t_fallback;
    go(2'b10, 8'h00);
    flush_and_expect("R4 last FF", 1'b1, 1'b1);
    go(2'b10, 8'h00);
    flush_and_expect("R4 last not FF", 1'b0, 1'b0);
  endtask

  task automatic t_ignore;
    give(8'hC9);
    check("R8 idle byte no done", done, 0);
    check("R8 idle byte no req", byte_req, 0);
    go(2'b00, 8'hC9);
    go(2'b10, 8'h11);
    check("R8 start while busy ignored", tx_byte, 8'h00);
    give(8'hC9);
    give(8'h00);
    check("R8 original op completes", ok, 1);
  endtask

  task automatic t_reserved;
    go(2'b11, 8'hAA);
    check("R9 reserved done", done, 1);
    check("R9 reserved ok", ok, 0);
    check("R9 no byte request", byte_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_echo_fast();
    t_echo_late();
    t_echo_fail();
    t_stat_fail();
    t_hdr();
    t_fallback();
    t_ignore();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule